// File: doc/BRIEF.md
# USB Core Suspend Clock Gating Controller

This block decides which clock domains of a USB on-the-go core keep running while the bus is suspended. Software writes one control register. One bit stops the 48 MHz line-side domain and another bit gates the core's system-clock domain. A third bit asks the power controller for deep sleep. The block turns these bits into registered clock-enable outputs for the line-side domain, the system domain and the data FIFO. It also drives the deep-sleep request.

The register interface runs on the free-running system clock, so software can read and write it while the core logic is gated. The data FIFO receives a clock enable only in the cycle after the core signals an access. Deep sleep is granted only from the suspended state, and only once the line-side clock stop is already in force. A rejected request raises an error flag instead.

A resume or remote-wakeup event on the line can arrive with no clock running. The block captures it in a flop with an asynchronous set and passes it through a two-stage synchroniser. The synchronised event then clears every gating bit and restarts every clock. When a wake actually restarts gated clocks, a status flag records it.

Top module: `usb_clkgate_ctrl`

## Requirements
- R1: After reset the line-side and system clock enables are high, the FIFO enable and the deep-sleep request are low, and the register reads 0.
- R2: Bit 0 of the register is the line-side stop. Writing 1 there makes bit 0 read 1 after the write edge and drops `phy_clk_en` after the following edge. Writing 0 restores it on the same timing.
- R3: Bit 1 is the system-domain gate. Writing 1 drops `sys_clk_en` one edge after the register updates. The register stays writable and readable while the gate is set.
- R4: `fifo_clk_en` is high in exactly the cycle after a cycle in which `fifo_access` is high and the register's bit 1 is clear. In every other cycle it is low.
- R5: Bit 2 is the deep-sleep request. A write with bit 2 set is accepted only when bit 0 already reads 1, the same write keeps bit 0 at 1, and `bus_suspended` is high. `deep_sleep_req` then equals bit 2 from the write edge onward.
- R6: A write with bit 2 set that fails the condition of R5 leaves bit 2 at 0 and sets error flag bit 3. Writing 1 to bit 3 clears that flag.
- R7: A rising edge on `wake_line`, even one much shorter than a clock period, clears bits 0 to 2 on the third rising clock edge after it. All clock enables are back high one edge later.
- R8: Wake flag bit 4 is set when a synchronised wake arrives while any of bits 0 to 2 is set. Writing 1 to bit 4 clears it.
- R9: A synchronised wake overrides a register write in the same cycle. Gating bits written then stay 0.
- R10: Writing 0 to bit 3 or bit 4 leaves those flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (bits 0 to 4, rest zero) |
| bus_suspended | input | 1 | Core reports the bus is in suspend |
| fifo_access | input | 1 | Core will access the data FIFO |
| wake_line | input | 1 | Asynchronous resume or remote-wakeup event |
| phy_clk_en | output | 1 | Clock enable for the 48 MHz line-side domain |
| sys_clk_en | output | 1 | Clock enable for the gated system domain |
| fifo_clk_en | output | 1 | Clock enable for the data FIFO |
| deep_sleep_req | output | 1 | Deep-sleep request to the power controller |

## Verification
A software write and a synchronised wake can land on the same clock edge, and the wake must win. The bench provokes this with a short wake pulse shortly after one edge. It then times a write that sets both gating bits so the write is sampled on the third edge after that edge. This is the edge where the synchronised wake acts. The collision is judged by the register reading 0 right after that edge, with no wake flag because nothing was gated before it. A later plain write of the same value then shows the write path itself works.

// File: rtl/usb_cg_pkg.sv
// Package: shared bit positions and state type for the clock gating controller.
// Assumes the control register is at least CG_CTRL_BITS wide.
package usb_cg_pkg;
    localparam int CG_BIT_STOP  = 0;
    localparam int CG_BIT_GATE  = 1;
    localparam int CG_BIT_SLEEP = 2;
    localparam int CG_BIT_ERR   = 3;
    localparam int CG_BIT_WAKE  = 4;
    localparam int CG_CTRL_BITS = 5;

    // Field order matches the bit positions above (LSB is stop).
    typedef struct packed {
        logic wake_flag;
        logic err_flag;
        logic sleep;
        logic gate_sys;
        logic stop_phy;
    } cg_state_t;
endpackage

// File: rtl/cg_wake_sync.sv
// Module: cg_wake_sync
// Captures an asynchronous wake edge in an asynchronously set flop, then moves it
// into the clk domain through SYNC_STAGES flops. The capture flop is cleared from
// the clk domain once the event has crossed. Assumes SYNC_STAGES >= 2 and that a
// new wake edge does not arrive while the clear is pending.
module cg_wake_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_line,
    output logic wake_seen
);
    localparam int LAST = SYNC_STAGES - 1;

    logic                   clr_q;
    logic                   evt_q;
    logic [SYNC_STAGES-1:0] sync_q;

    // Capture the wake edge with no clock; cleared from the clk domain.
    always_ff @(posedge wake_line or posedge clr_q) begin
        if (clr_q) evt_q <= 1'b0;
        else       evt_q <= 1'b1;
    end

    // Shift the captured event through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], evt_q};
    end

    // Request clearing of the capture flop once the event has crossed (and in reset).
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b1;
        else        clr_q <= sync_q[LAST];
    end

    assign wake_seen = sync_q[LAST];
endmodule

// File: rtl/cg_ctrl_regs.sv
// Module: cg_ctrl_regs
// Control and status register with stop sequencing. Holds the stop, gate and
// sleep bits plus two write-one-to-clear flags. A synchronised wake has priority
// over any write. Assumes wake_seen is already in the clk domain.
module cg_ctrl_regs
    import usb_cg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              suspended,
    input  logic              wake_seen,
    output cg_state_t         st_q
);
    cg_state_t st_d;
    logic      sleep_ok;
    logic      any_gated;

    assign sleep_ok  = wdata[CG_BIT_STOP] && st_q.stop_phy && suspended;
    assign any_gated = st_q.stop_phy || st_q.gate_sys || st_q.sleep;

    // Next state: apply the write, then let a wake override the gating bits.
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.stop_phy = wdata[CG_BIT_STOP];
            st_d.gate_sys = wdata[CG_BIT_GATE];
            st_d.sleep    = wdata[CG_BIT_SLEEP] && sleep_ok;
            if (wdata[CG_BIT_SLEEP] && !sleep_ok) st_d.err_flag = 1'b1;
            else if (wdata[CG_BIT_ERR])           st_d.err_flag = 1'b0;
            if (wdata[CG_BIT_WAKE])               st_d.wake_flag = 1'b0;
        end
        if (wake_seen) begin
            st_d.stop_phy = 1'b0;
            st_d.gate_sys = 1'b0;
            st_d.sleep    = 1'b0;
            if (any_gated) st_d.wake_flag = 1'b1;
        end
    end

    // Register the control state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SLEEP_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sleep |-> st_q.stop_phy);  // R5
    AST_SLEEP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[CG_BIT_SLEEP] && !(st_q.stop_phy && wdata[CG_BIT_STOP] && suspended))
        |=> (st_q.err_flag && !st_q.sleep));  // R6
    AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_seen |=> (!st_q.stop_phy && !st_q.gate_sys && !st_q.sleep));  // R9
    AST_WAKE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_seen && (st_q.stop_phy || st_q.gate_sys || st_q.sleep)) |=> st_q.wake_flag);  // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[CG_BIT_WAKE] && st_q.wake_flag) |=> st_q.wake_flag);  // R10
endmodule

// File: rtl/cg_enable_gen.sv
// Module: cg_enable_gen
// Registered clock enables. One flop per gated domain, high when the domain's
// gate request is clear, plus a FIFO enable that follows access requests while
// the system domain runs. Enables change only right after a clk edge.
// Assumes gate requests are synchronous to clk.
module cg_enable_gen #(
    parameter int NUM_DOM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] gate_req,
    input  logic               fifo_req,
    input  logic               sys_gated,
    output logic [NUM_DOM-1:0] dom_en,
    output logic               fifo_en
);
    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        // Domain enable: register the inverted gate request.
        always_ff @(posedge clk) begin
            if (!rst_n) dom_en[i] <= 1'b1;
            else        dom_en[i] <= !gate_req[i];
        end

        AST_DOM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            gate_req[i] |=> !dom_en[i]);  // R2
    end

    // FIFO enable: one cycle per access request, none while the system domain is gated.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_en <= 1'b0;
        else        fifo_en <= fifo_req && !sys_gated;
    end

    AST_FIFO_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_req && !sys_gated) |=> fifo_en);  // R4
    AST_FIFO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_req || sys_gated) |=> !fifo_en);  // R4
endmodule

// File: rtl/usb_clkgate_ctrl.sv
// Module: usb_clkgate_ctrl (top)
// Suspend clock gating controller for a USB core. It combines the wake
// synchroniser, the control register and the enable generator. Assumes clk runs
// freely (it also clocks the register interface) and that wake_line may toggle
// with no clock.
module usb_clkgate_ctrl
    import usb_cg_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_suspended,
    input  logic              fifo_access,
    input  logic              wake_line,
    output logic              phy_clk_en,
    output logic              sys_clk_en,
    output logic              fifo_clk_en,
    output logic              deep_sleep_req
);
    localparam int NUM_DOM = 2;

    cg_state_t          st;
    logic               wake_seen;
    logic [NUM_DOM-1:0] gate_req;
    logic [NUM_DOM-1:0] dom_en;

    cg_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_line (wake_line),
        .wake_seen (wake_seen)
    );

    cg_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .suspended (bus_suspended),
        .wake_seen (wake_seen),
        .st_q      (st)
    );

    assign gate_req = {st.gate_sys, st.stop_phy};

    cg_enable_gen #(.NUM_DOM(NUM_DOM)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_req  (gate_req),
        .fifo_req  (fifo_access),
        .sys_gated (st.gate_sys),
        .dom_en    (dom_en),
        .fifo_en   (fifo_clk_en)
    );

    assign phy_clk_en     = dom_en[0];
    assign sys_clk_en     = dom_en[1];
    assign deep_sleep_req = st.sleep;

    // Read data: status bits zero-extended to the bus width.
    always_comb begin
        reg_rdata                 = '0;
        reg_rdata[CG_CTRL_BITS-1:0] = st;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && phy_clk_en && sys_clk_en && !deep_sleep_req));  // R1
    AST_SYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        st.gate_sys |=> !sys_clk_en);  // R3
endmodule

// File: tb/usb_clkgate_ctrl_tb.sv
module usb_clkgate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int NVEC       = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              bus_suspended = 1'b0;
    logic              fifo_access = 1'b0;
    logic              wake_line = 1'b0;
    logic              phy_clk_en, sys_clk_en, fifo_clk_en, deep_sleep_req;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_clkgate_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_suspended(bus_suspended), .fifo_access(fifo_access),
        .wake_line(wake_line), .phy_clk_en(phy_clk_en), .sys_clk_en(sys_clk_en),
        .fifo_clk_en(fifo_clk_en), .deep_sleep_req(deep_sleep_req)
    );

    // Vector: {wdata[8], suspended, fifo_access, exp_rdata[8], exp {phy,sys,fifo,sleep}}
    localparam logic [21:0] VEC [NVEC] = '{
        {8'h01, 1'b1, 1'b0, 8'h01, 4'b0100},  // stop line-side clock
        {8'h05, 1'b1, 1'b0, 8'h05, 4'b0101},  // sleep accepted
        {8'h07, 1'b1, 1'b1, 8'h07, 4'b0001},  // gate system, FIFO blocked
        {8'h01, 1'b1, 1'b1, 8'h01, 4'b0110},  // ungate, FIFO runs
        {8'h00, 1'b1, 1'b1, 8'h00, 4'b1110},  // all running
        {8'h04, 1'b1, 1'b0, 8'h08, 4'b1100},  // sleep without stop: error
        {8'h08, 1'b1, 1'b0, 8'h00, 4'b1100},  // clear error
        {8'h01, 1'b0, 1'b0, 8'h01, 4'b0100},  // stop while not suspended
        {8'h05, 1'b0, 1'b0, 8'h09, 4'b0100},  // sleep not suspended: error
        {8'h08, 1'b0, 1'b0, 8'h00, 4'b1100},  // clear error and stop
        {8'h02, 1'b0, 1'b1, 8'h02, 4'b1000},  // gate system only
        {8'h00, 1'b0, 1'b0, 8'h00, 4'b1100}   // release
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One write strobe; returns at the negedge after the write edge.
    task automatic do_write(input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", 32'(reg_rdata), 32'h0);
        check("R1 phy_clk_en", 32'(phy_clk_en), 32'h1);
        check("R1 sys_clk_en", 32'(sys_clk_en), 32'h1);
        check("R1 fifo_clk_en", 32'(fifo_clk_en), 32'h0);
        check("R1 deep_sleep_req", 32'(deep_sleep_req), 32'h0);

        // Table walk: R2 R3 R4 R5 R6 register and enable behaviour
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            reg_wr_en     = 1'b1;
            reg_wdata     = VEC[i][21:14];
            bus_suspended = VEC[i][13];
            fifo_access   = VEC[i][12];
            @(posedge clk);
            @(negedge clk);
            reg_wr_en = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R5 R6 rdata vec %0d", i), 32'(reg_rdata), 32'(VEC[i][11:4]));
            check($sformatf("R2 phy_clk_en vec %0d", i), 32'(phy_clk_en), 32'(VEC[i][3]));
            check($sformatf("R3 sys_clk_en vec %0d", i), 32'(sys_clk_en), 32'(VEC[i][2]));
            check($sformatf("R4 fifo_clk_en vec %0d", i), 32'(fifo_clk_en), 32'(VEC[i][1]));
            check($sformatf("R5 deep_sleep_req vec %0d", i), 32'(deep_sleep_req), 32'(VEC[i][0]));
        end

        // R4 single access cycle gives exactly one enable cycle
        @(negedge clk);
        fifo_access = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fifo_access = 1'b0;
        check("R4 fifo pulse on", 32'(fifo_clk_en), 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R4 fifo pulse off", 32'(fifo_clk_en), 32'h0);

        // R7 R8 short wake pulse restarts everything from full stop
        bus_suspended = 1'b1;
        do_write(8'h01);
        do_write(8'h07);
        check("R5 sleep before wake", 32'(deep_sleep_req), 32'h1);
        #1 wake_line = 1'b1;
        #2 wake_line = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R7 not cleared too early", 32'(reg_rdata[2:0]), 32'h7);
        @(posedge clk);
        @(negedge clk);
        check("R7 R8 rdata after wake", 32'(reg_rdata), 32'h10);
        check("R7 sleep dropped", 32'(deep_sleep_req), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R7 phy_clk_en back", 32'(phy_clk_en), 32'h1);
        check("R7 sys_clk_en back", 32'(sys_clk_en), 32'h1);
        repeat (4) @(posedge clk);

        // R10 writing zero keeps flags; R8 write one clears wake flag
        do_write(8'h00);
        check("R10 wake flag kept", 32'(reg_rdata), 32'h10);
        do_write(8'h10);
        check("R8 wake flag cleared", 32'(reg_rdata), 32'h00);

        // R9 write and synchronised wake on the same edge
        @(negedge clk);
        #1 wake_line = 1'b1;
        #2 wake_line = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = 8'h03;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R9 wake overrides write", 32'(reg_rdata), 32'h00);
        repeat (4) @(posedge clk);
        do_write(8'h03);
        check("R9 later write lands", 32'(reg_rdata), 32'h03);
        do_write(8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule